// File: doc/BRIEF.md
# Raw Symbol Loopback Selector

This block chooses what a serial link PHY transmits while the link is in its normal operating power state. In normal operation, each symbol slot carries the encoded 10-bit transmit symbol supplied by the parallel interface. When the link partner's controller asks for loopback, the block switches to retransmitting the received 10-bit symbols as raw bit patterns. It never scrambles them, never fixes disparity and never checks them for legality.

Received symbols pass through a small FIFO that absorbs the rate difference between the two ends. When the FIFO runs low, the block stretches a SKP ordered set by sending the SKP symbol it has just retransmitted a second time. Switching in and out of loopback happens only at a symbol slot (`symTick`). The received stream always passes straight through to the parallel receive outputs, whether or not loopback is active.

Top module: `lbsw_top`

## Requirements
- R1: When loopback is not selected at a tick, `txSymOut` takes the value of `txIn` on that clock edge and `lbActive` is 0.
- R2: On cycles with `symTick` low, `txSymOut` and `lbActive` keep their values.
- R3: Loopback is selected at a tick only if `lbReq` is 1 and `pwrState` is 2'b00. The codes 2'b01, 2'b10 and 2'b11 never enable it. `lbActive` shows the state selected at the most recent tick.
- R4: While loopback is active, every tick pops the oldest FIFO symbol and places it on `txSymOut` bit for bit, and this includes illegal codes such as 10'h3FF. A received symbol enters the FIFO on an edge where `rxValid` is 1 and `lbActive` is already 1. The earliest tick that can send it is the following edge.
- R5: If a tick selects loopback while the FIFO holds nothing, `txSymOut` becomes the SKP code 10'b0011110100 (10'h0F4).
- R6: If the popped symbol is either SKP code (10'h0F4 or 10'h30B) and the FIFO held at most `LOW_MARK` (default 2) entries before that pop, the next loopback tick sends the same SKP code again without popping. This happens once per popped SKP.
- R7: If the popped SKP leaves the FIFO with more than `LOW_MARK` entries before the pop, no SKP is added.
- R8: The first tick that finds `lbReq` low or `pwrState` not 2'b00 sends `txIn` on that same edge. That tick also discards the FIFO contents and any pending SKP insertion, so a later entry into loopback starts with an empty FIFO.
- R9: The FIFO holds `DEPTH` (default 8) symbols. A received symbol that arrives while the FIFO is full and nothing is popped is dropped.
- R10: `rxDataOut` equals `rxSym` and `rxValidOut` equals `rxValid` at all times, in either mode.
- R11: With `rstN` low, `txSymOut` is 0, `lbActive` is 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lbReq | input | 1 | Loopback request from the link controller |
| pwrState | input | 2 | Power state code; 2'b00 is the operating state |
| symTick | input | 1 | Symbol slot strobe; output and mode change only here |
| rxSym | input | 10 | Received raw 10-bit symbol |
| rxValid | input | 1 | `rxSym` holds a new symbol |
| txIn | input | 10 | Encoded transmit symbol from the parallel interface |
| txSymOut | output | 10 | Symbol to transmit |
| lbActive | output | 1 | Loopback selected at the last symbol slot |
| rxDataOut | output | 10 | Received symbol passed to the parallel receive side |
| rxValidOut | output | 1 | Valid flag passed to the parallel receive side |

## Verification
A FIFO pointer or occupancy count that has gone wrong shows up on `txSymOut`. Looped symbols come out of order or repeated, or a filler SKP appears where a stored symbol was due. The error is visible within one or two ticks of the faulty push or pop.

A stale insertion flag shows as a doubled SKP, or a missing one, on the tick right after a SKP is popped. A mode register that disagrees with the request shows on `lbActive` and on `txSymOut` at the very first tick after the request changes. The stimulus is built so that each of these faults gives a symbol value that no correct sequence would produce at that point.

// File: rtl/lbsw_pkg.sv
package lbsw_pkg;
  localparam int SYM_W = 10;
  localparam logic [SYM_W-1:0] SKP_POS = 10'b0011110100;
  localparam logic [SYM_W-1:0] SKP_NEG = 10'b1100001011;
  localparam logic [1:0] PWR_RUN = 2'b00;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic loadOut;
    logic selLoop;
    logic useHold;
    logic useFill;
  } lbStrobes_t;

  typedef struct packed {
    logic empty;
    logic full;
    logic low;
    logic headSkp;
  } lbStatus_t;
endpackage

// File: rtl/lbsw_ctrl.sv
module lbsw_ctrl
  import lbsw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lbReq,
  input  logic [1:0] pwrState,
  input  logic       symTick,
  input  logic       rxValid,
  input  lbStatus_t  stat,
  output lbStrobes_t strobes,
  output logic       activeOut
);
  logic activeQ, pendQ, pendNext;
  logic wantLoop, fifoAvail;

  always_comb begin
    wantLoop  = lbReq && (pwrState == PWR_RUN);
    // FIFO contents count only while already in loopback; otherwise they are being flushed
    fifoAvail = activeQ && !stat.empty;
    strobes   = '0;
    strobes.loadOut = symTick;
    strobes.selLoop = wantLoop;
    strobes.flush   = !activeQ;
    if (symTick && wantLoop) begin
      if (pendQ)          strobes.useHold = 1'b1;
      else if (fifoAvail) strobes.pop     = 1'b1;
      else                strobes.useFill = 1'b1;
    end
    strobes.push = rxValid && activeQ && (!stat.full || strobes.pop);

    pendNext = pendQ;
    if (symTick) begin
      if (!wantLoop || pendQ) pendNext = 1'b0;
      else if (strobes.pop && stat.headSkp && stat.low) pendNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      pendQ   <= 1'b0;
    end else begin
      pendQ <= pendNext;
      if (symTick) activeQ <= wantLoop;
    end
  end

  assign activeOut = activeQ;
endmodule

// File: rtl/lbsw_datapath.sv
module lbsw_datapath
  import lbsw_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int LOW_MARK = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  lbStrobes_t       strobes,
  input  logic [SYM_W-1:0] rxSym,
  input  logic [SYM_W-1:0] txIn,
  output lbStatus_t        stat,
  output logic [SYM_W-1:0] txSymOut,
  output logic [$clog2(DEPTH+1)-1:0] occupancy
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [SYM_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [SYM_W-1:0] head, skpHold, nextOut;

  assign head = mem[rdPtr];

  always_comb begin
    stat.empty   = (count == '0);
    stat.full    = (count == CNT_W'(DEPTH));
    stat.low     = (count <= CNT_W'(LOW_MARK));
    stat.headSkp = (head == SKP_POS) || (head == SKP_NEG);
    if (!strobes.selLoop)     nextOut = txIn;
    else if (strobes.useHold) nextOut = skpHold;
    else if (strobes.useFill) nextOut = SKP_POS;
    else                      nextOut = head;
  end

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= rxSym;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      skpHold  <= SKP_POS;
      txSymOut <= '0;
    end else begin
      if (strobes.loadOut) txSymOut <= nextOut;
      if (strobes.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (strobes.push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
        if (strobes.pop) begin
          rdPtr   <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
          skpHold <= head;
        end
        case ({strobes.push, strobes.pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  assign occupancy = count;
endmodule

// File: rtl/lbsw_top.sv
module lbsw_top
  import lbsw_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int LOW_MARK = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lbReq,
  input  logic [1:0]       pwrState,
  input  logic             symTick,
  input  logic [SYM_W-1:0] rxSym,
  input  logic             rxValid,
  input  logic [SYM_W-1:0] txIn,
  output logic [SYM_W-1:0] txSymOut,
  output logic             lbActive,
  output logic [SYM_W-1:0] rxDataOut,
  output logic             rxValidOut
);
  lbStrobes_t strobes;
  lbStatus_t  stat;
  logic [$clog2(DEPTH+1)-1:0] occupancy;

  lbsw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lbReq(lbReq), .pwrState(pwrState),
    .symTick(symTick), .rxValid(rxValid), .stat(stat),
    .strobes(strobes), .activeOut(lbActive)
  );

  lbsw_datapath #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxSym(rxSym),
    .txIn(txIn), .stat(stat), .txSymOut(txSymOut), .occupancy(occupancy)
  );

  // Receive side is untouched by the transmit selection (R10)
  assign rxDataOut  = rxSym;
  assign rxValidOut = rxValid;
endmodule

// File: rtl/lbsw_chk.sv
module lbsw_chk #(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       lbReq,
  input logic [1:0] pwrState,
  input logic       symTick,
  input logic [9:0] txIn,
  input logic [9:0] txSymOut,
  input logic       lbActive,
  input logic [$clog2(DEPTH+1)-1:0] occupancy
);
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !symTick |=> ($stable(txSymOut) && $stable(lbActive)));

  p_enter_run_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lbActive) |-> ($past(lbReq) && $past(pwrState) == 2'b00));

  p_off_outside_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    (symTick && pwrState != 2'b00) |=> !lbActive);

  p_normal_path_r1: assert property (@(posedge clk) disable iff (!rstN)
    (symTick && !(lbReq && pwrState == 2'b00)) |=> (txSymOut == $past(txIn)));

  p_exit_now_r8: assert property (@(posedge clk) disable iff (!rstN)
    (symTick && !lbReq) |=> !lbActive);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind lbsw_top lbsw_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .lbReq(lbReq), .pwrState(pwrState),
  .symTick(symTick), .txIn(txIn), .txSymOut(txSymOut),
  .lbActive(lbActive), .occupancy(occupancy)
);

// File: tb/lbsw_top_test.sv
module lbsw_top_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       lbReq;
  logic [1:0] pwrState;
  logic       symTick;
  logic [9:0] rxSym;
  logic       rxValid;
  logic [9:0] txIn;
  logic [9:0] txSymOut;
  logic       lbActive;
  logic [9:0] rxDataOut;
  logic       rxValidOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lbsw_top uut (
    .clk(clk), .rstN(rstN), .lbReq(lbReq), .pwrState(pwrState),
    .symTick(symTick), .rxSym(rxSym), .rxValid(rxValid), .txIn(txIn),
    .txSymOut(txSymOut), .lbActive(lbActive), .rxDataOut(rxDataOut),
    .rxValidOut(rxValidOut)
  );

  typedef struct packed {
    logic       req;
    logic [1:0] pwr;
    logic       tick;
    logic       rxV;
    logic [9:0] rx;
    logic [9:0] tx;
    logic [9:0] expTx;
    logic       expAct;
    logic [3:0] reqId;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 1'b1, 1'b1, 10'h201, 10'h111, 10'h111, 1'b0, 4'd1},  // R1 normal path
    '{1'b0, 2'b00, 1'b1, 1'b0, 10'h000, 10'h122, 10'h122, 1'b0, 4'd1},  // R1
    '{1'b1, 2'b10, 1'b1, 1'b1, 10'h202, 10'h133, 10'h133, 1'b0, 4'd3},  // R3 request in low-power state
    '{1'b1, 2'b11, 1'b1, 1'b0, 10'h000, 10'h144, 10'h144, 1'b0, 4'd3},  // R3 illegal code
    '{1'b1, 2'b00, 1'b0, 1'b1, 10'h2FF, 10'h155, 10'h144, 1'b0, 4'd2},  // R2 no slot, no switch
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h203, 10'h166, 10'h0F4, 1'b1, 4'd5},  // R5 entry, empty FIFO
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h3FF, 10'h166, 10'h0F4, 1'b1, 4'd5},  // R5
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h204, 10'h166, 10'h3FF, 1'b1, 4'd4},  // R4 illegal code looped raw
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h30B, 10'h166, 10'h204, 1'b1, 4'd4},  // R4
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h205, 10'h166, 10'h30B, 1'b1, 4'd6},  // R6 SKP popped, low
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h206, 10'h166, 10'h30B, 1'b1, 4'd6},  // R6 inserted copy
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h207, 10'h166, 10'h205, 1'b1, 4'd6},  // R6 only once
    '{1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h166, 10'h206, 1'b1, 4'd4},  // R4
    '{1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h166, 10'h207, 1'b1, 4'd4},  // R4
    '{1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h166, 10'h0F4, 1'b1, 4'd5},  // R5 drained
    '{1'b1, 2'b00, 1'b0, 1'b1, 10'h0F4, 10'h166, 10'h0F4, 1'b1, 4'd2},  // R2 fill while idle slot
    '{1'b1, 2'b00, 1'b0, 1'b1, 10'h208, 10'h166, 10'h0F4, 1'b1, 4'd2},  // R2
    '{1'b1, 2'b00, 1'b0, 1'b1, 10'h209, 10'h166, 10'h0F4, 1'b1, 4'd2},  // R2
    '{1'b1, 2'b00, 1'b1, 1'b1, 10'h20A, 10'h166, 10'h0F4, 1'b1, 4'd7},  // R7 SKP popped, deep FIFO
    '{1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h166, 10'h208, 1'b1, 4'd7},  // R7 no copy added
    '{1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h166, 10'h209, 1'b1, 4'd7},  // R7
    '{1'b0, 2'b00, 1'b1, 1'b1, 10'h20B, 10'h177, 10'h177, 1'b0, 4'd8},  // R8 immediate exit
    '{1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h188, 10'h0F4, 1'b1, 4'd8},  // R8 FIFO was discarded
    '{1'b1, 2'b01, 1'b1, 1'b0, 10'h000, 10'h199, 10'h199, 1'b0, 4'd3},  // R3 leaving run state
    '{1'b0, 2'b00, 1'b1, 1'b0, 10'h000, 10'h1AA, 10'h1AA, 1'b0, 4'd1}   // R1
  };

  task automatic checkVal(input string tag, input logic [9:0] act, input logic [9:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic req, input logic [1:0] pwr, input logic tick,
                       input logic rxV, input logic [9:0] rx, input logic [9:0] tx);
    @(negedge clk);
    lbReq = req; pwrState = pwr; symTick = tick;
    rxValid = rxV; rxSym = rx; txIn = tx;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; lbReq = 1'b0; pwrState = 2'b00; symTick = 1'b0;
    rxSym = '0; rxValid = 1'b0; txIn = '0;
    repeat (3) @(posedge clk);
    #1;
    checkVal("R11 reset txSymOut", txSymOut, 10'h000);
    checkVal("R11 reset lbActive", {9'd0, lbActive}, 10'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].req, VECS[i].pwr, VECS[i].tick, VECS[i].rxV, VECS[i].rx, VECS[i].tx);
      checkVal($sformatf("R%0d vec %0d txSymOut", VECS[i].reqId, i), txSymOut, VECS[i].expTx);
      checkVal($sformatf("R%0d vec %0d lbActive", VECS[i].reqId, i), {9'd0, lbActive}, {9'd0, VECS[i].expAct});
      // R10 receive pass-through, inputs still held
      checkVal($sformatf("R10 vec %0d rxDataOut", i), rxDataOut, VECS[i].rx);
      checkVal($sformatf("R10 vec %0d rxValidOut", i), {9'd0, rxValidOut}, {9'd0, VECS[i].rxV});
    end

    // R9: fill past capacity with no slots, then drain
    drive(1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h1BB);
    checkVal("R9 entry fill", txSymOut, 10'h0F4);
    for (int k = 0; k < 10; k++) drive(1'b1, 2'b00, 1'b0, 1'b1, 10'(10'h210 + k), 10'h1BB);
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h1BB);
      checkVal($sformatf("R9 drain %0d", k), txSymOut, 10'(10'h210 + k));
    end
    drive(1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h1BB);
    checkVal("R9 overflow symbols dropped", txSymOut, 10'h0F4);

    // R11: reset in the middle of loopback
    drive(1'b1, 2'b00, 1'b1, 1'b1, 10'h220, 10'h1CC);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkVal("R11 async reset txSymOut", txSymOut, 10'h000);
    checkVal("R11 async reset lbActive", {9'd0, lbActive}, 10'd0);
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b1, 2'b00, 1'b1, 1'b0, 10'h000, 10'h1DD);
    checkVal("R11 FIFO empty after reset", txSymOut, 10'h0F4);
    drive(1'b0, 2'b00, 1'b1, 1'b0, 10'h000, 10'h1EE);
    checkVal("R1 after reset exit", txSymOut, 10'h1EE);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule